// File: doc/BRIEF.md
# Log-Depth Priority Encoder

This block turns a request vector into the binary position of a single winning request and a flag that says whether any request is present. A compile-time setting chooses which end of the vector wins: either the lowest set position or the highest. The block is purely combinational. Its outputs follow the request vector within the same cycle, with no clock and no state.

The logic is a balanced binary tree. The request vector is zero-extended to the next power of two. The first tree level looks at the bits in pairs and produces a presence flag and a one-bit partial index for each pair. Each later level joins two neighbouring partial results. The presence flag of the preferred half decides which half's partial index is passed up, and one new upper index bit records that choice. The tree depth is the base-2 logarithm of the padded width. A one-bit request vector is handled without a tree.

Top module: `prio_tree_enc`

## Requirements
- R1: `any_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: With `PRIO = PRIO_LOW_FIRST` (enum value 0), `idx_o` is the smallest position j for which `req_i[j]` is 1.
- R3: With `PRIO = PRIO_HIGH_FIRST` (enum value 1), `idx_o` is the largest position j for which `req_i[j]` is 1.
- R4: When `req_i` is all zeros, `any_o` is 0 and `idx_o` is 0, whichever priority is chosen.
- R5: When `WIDTH` is not a power of two, the zero padding never wins: `idx_o` is always below `WIDTH` and matches R2 or R3.
- R6: With `WIDTH = 1`, `idx_o` is a single bit held at 0, and `any_o` equals `req_i[0]`.
- R7: Whenever `any_o` is 1, the bit `req_i[idx_o]` is 1.
- R8: With all request bits set, `idx_o` is 0 for low-first priority and `WIDTH-1` for high-first priority.
- R9: `idx_o` is `max(1, ceil(log2(WIDTH)))` bits wide, and both outputs settle within the same cycle as the input change, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | WIDTH | Request vector, one bit per requester |
| any_o | output | 1 | High when any request bit is set |
| idx_o | output | IDX_W | Binary position of the winning request, 0 when none |

## Verification
An 8-bit encoder is driven through all 256 patterns with each priority setting. This separates the lowest-wins and highest-wins choices on every pattern where more than one bit is set. A 5-bit low-first instance is also run exhaustively, and a 13-bit high-first instance gets random and single-hot patterns. These two show that padded positions can never be chosen and that the index stays below the width. The empty vector, the all-ones vector and the one-bit and two-bit widths check the idle value, the endpoint indices and the case with no tree.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic {
        PRIO_LOW_FIRST  = 1'b0,
        PRIO_HIGH_FIRST = 1'b1
    } prio_e;

    // Result of one leaf pair: presence and one index bit.
    typedef struct packed {
        logic hit;
        logic sel;
    } pair_res_t;

    function automatic int tree_levels(input int w);
        return (w <= 1) ? 0 : $clog2(w);
    endfunction

    function automatic int idx_bits(input int w);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

    function automatic int pad_bits(input int w);
        return (w <= 1) ? 1 : (1 << $clog2(w));
    endfunction

endpackage

// File: rtl/pe_leaf.sv
module pe_leaf
    import pe_pkg::*;
#(
    parameter prio_e PRIO = PRIO_LOW_FIRST
) (
    input  logic [1:0] pair_i,
    output logic       hit_o,
    output logic       sel_o
);

    pair_res_t res;

    always_comb begin
        res.hit = pair_i[0] | pair_i[1];
        if (PRIO == PRIO_LOW_FIRST) begin
            // lower bit dominates: index bit is 1 only when it is clear
            res.sel = ~pair_i[0];
        end else begin
            // upper bit dominates: index bit follows it directly
            res.sel = pair_i[1];
        end
    end

    assign hit_o = res.hit;
    assign sel_o = res.sel;

endmodule

// File: rtl/pe_merge.sv
module pe_merge
    import pe_pkg::*;
#(
    parameter int    IW   = 1,
    parameter prio_e PRIO = PRIO_LOW_FIRST
) (
    input  logic          lo_hit_i,
    input  logic [IW-1:0] lo_idx_i,
    input  logic          hi_hit_i,
    input  logic [IW-1:0] hi_idx_i,
    output logic          hit_o,
    output logic [IW:0]   idx_o
);

    logic take_hi;

    always_comb begin
        if (PRIO == PRIO_LOW_FIRST) begin
            take_hi = ~lo_hit_i;
        end else begin
            take_hi = hi_hit_i;
        end
        hit_o = lo_hit_i | hi_hit_i;
        idx_o = take_hi ? {1'b1, hi_idx_i} : {1'b0, lo_idx_i};
    end

endmodule

// File: rtl/prio_tree_enc.sv
module prio_tree_enc
    import pe_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter prio_e PRIO  = PRIO_LOW_FIRST,
    localparam int   IDX_W = idx_bits(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int LEVELS = tree_levels(WIDTH);
    localparam int PAD_W  = pad_bits(WIDTH);

    generate
        if (WIDTH == 1) begin : g_single
            assign any_o = req_i[0];
            assign idx_o = '0;
        end else begin : g_tree
            logic [PAD_W-1:0] req_pad;
            logic             top_hit;
            logic [IDX_W-1:0] top_idx;

            assign req_pad = PAD_W'(req_i);

            for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
                localparam int CNT = PAD_W >> (l + 1);
                logic [CNT-1:0]      hit;
                logic [CNT-1:0][l:0] idx;

                for (genvar n = 0; n < CNT; n++) begin : g_node
                    if (l == 0) begin : g_leaf
                        pe_leaf #(.PRIO(PRIO)) u_leaf (
                            .pair_i (req_pad[2*n+1:2*n]),
                            .hit_o  (hit[n]),
                            .sel_o  (idx[n][0])
                        );
                    end else begin : g_join
                        pe_merge #(.IW(l), .PRIO(PRIO)) u_merge (
                            .lo_hit_i (g_lvl[l-1].hit[2*n]),
                            .lo_idx_i (g_lvl[l-1].idx[2*n]),
                            .hi_hit_i (g_lvl[l-1].hit[2*n+1]),
                            .hi_idx_i (g_lvl[l-1].idx[2*n+1]),
                            .hit_o    (hit[n]),
                            .idx_o    (idx[n])
                        );
                    end
                end
            end

            assign top_hit = g_lvl[LEVELS-1].hit[0];
            assign top_idx = g_lvl[LEVELS-1].idx[0];
            assign any_o   = top_hit;
            assign idx_o   = top_hit ? top_idx : '0;
        end
    endgenerate

endmodule

// File: rtl/pe_check.sv
module pe_check
    import pe_pkg::*;
#(
    parameter int    WIDTH = 8,
    parameter prio_e PRIO  = PRIO_LOW_FIRST,
    localparam int   IDX_W = idx_bits(WIDTH)
) (
    input logic [WIDTH-1:0] req_i,
    input logic             any_i,
    input logic [IDX_W-1:0] idx_i
);

    logic below_clear;
    logic above_clear;
    logic winner_set;

    always_comb begin
        below_clear = 1'b1;
        above_clear = 1'b1;
        winner_set  = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            if (req_i[j] && (j < int'(idx_i))) below_clear = 1'b0;
            if (req_i[j] && (j > int'(idx_i))) above_clear = 1'b0;
            if (req_i[j] && (j == int'(idx_i))) winner_set = 1'b1;
        end
    end

    always_comb begin
        assert_any_tracks_req_R1: assert (any_i == (|req_i));
        assert_idle_index_zero_R4: assert (any_i || (idx_i == '0));
        assert_index_in_range_R5: assert (int'(idx_i) < WIDTH);
        assert_winner_requested_R7: assert (!any_i || winner_set);
        if (PRIO == PRIO_LOW_FIRST) begin
            assert_nothing_lower_R2: assert (!any_i || below_clear);
        end else begin
            assert_nothing_higher_R3: assert (!any_i || above_clear);
        end
    end

endmodule

bind prio_tree_enc pe_check #(.WIDTH(WIDTH), .PRIO(PRIO)) u_pe_check (
    .req_i (req_i),
    .any_i (any_o),
    .idx_i (idx_o)
);

// File: tb/prio_tree_enc_bench.sv
module prio_tree_enc_bench;
    import pe_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    logic [7:0]  a_req = '0;  logic a_any;  logic [2:0] a_idx;
    logic [7:0]  b_req = '0;  logic b_any;  logic [2:0] b_idx;
    logic [4:0]  c_req = '0;  logic c_any;  logic [2:0] c_idx;
    logic [12:0] d_req = '0;  logic d_any;  logic [3:0] d_idx;
    logic [0:0]  e_req = '0;  logic e_any;  logic [0:0] e_idx;
    logic [1:0]  f_req = '0;  logic f_any;  logic [0:0] f_idx;

    prio_tree_enc #(.WIDTH(8), .PRIO(PRIO_LOW_FIRST)) u_prio_tree_enc (
        .req_i(a_req), .any_o(a_any), .idx_o(a_idx));
    prio_tree_enc #(.WIDTH(8), .PRIO(PRIO_HIGH_FIRST)) u_prio_tree_enc_hi8 (
        .req_i(b_req), .any_o(b_any), .idx_o(b_idx));
    prio_tree_enc #(.WIDTH(5), .PRIO(PRIO_LOW_FIRST)) u_prio_tree_enc_lo5 (
        .req_i(c_req), .any_o(c_any), .idx_o(c_idx));
    prio_tree_enc #(.WIDTH(13), .PRIO(PRIO_HIGH_FIRST)) u_prio_tree_enc_hi13 (
        .req_i(d_req), .any_o(d_any), .idx_o(d_idx));
    prio_tree_enc #(.WIDTH(1), .PRIO(PRIO_LOW_FIRST)) u_prio_tree_enc_w1 (
        .req_i(e_req), .any_o(e_any), .idx_o(e_idx));
    prio_tree_enc #(.WIDTH(2), .PRIO(PRIO_HIGH_FIRST)) u_prio_tree_enc_hi2 (
        .req_i(f_req), .any_o(f_any), .idx_o(f_idx));

    function automatic int ref_pick(input logic [15:0] r, input int w, input bit low);
        int k = 0;
        if (low) begin
            for (int j = w - 1; j >= 0; j--) if (r[j]) k = j;
        end else begin
            for (int j = 0; j < w; j++) if (r[j]) k = j;
        end
        return k;
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag_a, input string tag_b);
        check("R1", "a any", int'(a_any), int'(|a_req));
        check((a_req == 0) ? "R4" : tag_a, "a idx", int'(a_idx), ref_pick(16'(a_req), 8, 1'b1));
        if (a_any) check("R7", "a winner bit", int'(a_req[a_idx]), 1);
        check("R1", "b any", int'(b_any), int'(|b_req));
        check((b_req == 0) ? "R4" : tag_b, "b idx", int'(b_idx), ref_pick(16'(b_req), 8, 1'b0));
        check("R5", "c any", int'(c_any), int'(|c_req));
        check("R5", "c idx", int'(c_idx), ref_pick(16'(c_req), 5, 1'b1));
        check("R5", "d any", int'(d_any), int'(|d_req));
        check("R5", "d idx", int'(d_idx), ref_pick(16'(d_req), 13, 1'b0));
        check("R6", "e any", int'(e_any), int'(e_req[0]));
        check("R6", "e idx", int'(e_idx), 0);
        check("R3", "f any", int'(f_any), int'(|f_req));
        check("R3", "f idx", int'(f_idx), ref_pick(16'(f_req), 2, 1'b0));
    endtask

    task automatic apply(input logic [12:0] pat, input logic [12:0] dpat);
        @(posedge clk);
        a_req = pat[7:0];
        b_req = pat[7:0];
        c_req = pat[4:0];
        d_req = dpat;
        e_req = pat[0:0];
        f_req = pat[1:0];
        @(negedge clk);
    endtask

    initial begin
        // R4: idle state with an all-zero request vector
        @(negedge clk);
        check_all("R2", "R3");

        // R9: width of the index output for each configuration
        check("R9", "idx width w8", $bits(a_idx), 3);
        check("R9", "idx width w13", $bits(d_idx), 4);
        check("R9", "idx width w1", $bits(e_idx), 1);

        // R2 / R3 / R5 / R6: exhaustive small widths, random and one-hot at 13
        for (int i = 0; i < 4096; i++) begin
            logic [12:0] dp;
            dp = (i % 3 == 0) ? (13'd1 << (i % 13)) : 13'($urandom);
            apply(13'(i), dp);
            check_all("R2", "R3");
        end

        // R8: all ones at every width
        apply('1, '1);
        check("R8", "a idx all ones", int'(a_idx), 0);
        check("R8", "b idx all ones", int'(b_idx), 7);
        check("R8", "c idx all ones", int'(c_idx), 0);
        check("R8", "d idx all ones", int'(d_idx), 12);
        check("R8", "f idx all ones", int'(f_idx), 1);

        // R9: output follows an input change made mid-cycle with no clock edge
        #1;
        a_req = 8'b0110_0000;
        b_req = 8'b0110_0000;
        #0.5;
        check("R9", "a idx same cycle", int'(a_idx), 5);
        check("R9", "b idx same cycle", int'(b_idx), 6);

        // R4: back to empty after activity
        apply('0, '0);
        check_all("R2", "R3");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule